// File: doc/BRIEF.md
# Event-Driven Match Timer Core

This block is a free-running up-counter with a bank of compare values and a bank of events layered over them. Each event points at one compare (match) slot and asserts for one cycle when that slot equals the counter. A limit mask names the events that end a period: when one of them asserts, the counter restarts from zero on its next step. A match value of N-1 on the period event therefore gives a period of N counts, and other events placed at earlier values mark duty points inside the period.

Every match slot has a shadow reload value. Unless reloading is switched off, all slots take their shadow values at the moment a limit event restarts the counter. New compare values written to the shadows therefore only take effect from the next period, and a period in progress is never cut short. A prescaler slows counting to one step every P+1 clocks, and a halt bit freezes the counter, the prescaler and all events. Configuration goes through a simple word-addressed write/read port. The output is the vector of events that fired in the current cycle.

Top module: `match_event_timer`

## Requirements
- R1: After reset the control word reads 0x4, meaning halt is set. Every other register reads 0 and no event fires.
- R2: The register map is as follows. Configuration is at 0x000: bit 0 is unified mode and bit 7 disables reloading. Control is at 0x004: bit 2 is halt, bit 4 is count direction and bits 12:5 are the prescaler. Limit mask is at 0x008. Match slot n is at 0x100+4n and reload n at 0x200+4n. State mask e is at 0x300+8e and event control e at 0x304+8e; its bits 3:0 select the match slot and bits 13:12 select the trigger kind. Written fields read back unchanged. The unified-mode bit and the direction bit have no effect on counting.
- R3: When counting is enabled, the counter steps by one per prescaler tick. An event fires on a tick cycle in which its selected match slot equals the counter. Several events may select the same slot, and they then fire together.
- R4: When a firing event is in the limit mask, the next counter value is 0. A period event with match value M therefore fires every M+1 ticks.
- R5: While halt is set, no event fires and the counter holds its value. After halt is cleared, counting resumes from the held value.
- R6: With prescaler value P, the counter steps once every P+1 clocks. P = 0 means it steps on every clock.
- R7: An event fires only if its trigger kind is 1 (match only) and bit 0 of its state mask is set. Otherwise it never fires.
- R8: With reloading enabled (configuration bit 7 = 0), every match slot copies its reload value at a limit wrap. With bit 7 set, the match slots keep their values.
- R9: With an empty limit mask, the counter does not restart. An event fires once as the counter passes its match value and does not fire again.
- R10: If a bus write to a match slot lands on the same edge as a limit-wrap reload, the written value wins for that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_fired | output | 16 | Events firing in this cycle |

## Verification
The two functions that can fall on the same edge are the limit-wrap reload of the match slots and a bus write to one of those slots. The bench waits until it sees the period event asserted at a falling edge. It then drives a write of a new period value to that same slot at once, so the write lands on the wrap edge, where the reload copies a different shadow value. The next measured period must follow the written value, and the period after it must follow the shadow value again.

// File: rtl/mtim_pkg.sv
package mtim_pkg;

    localparam int CFG_UNIFY_BIT    = 0;
    localparam int CFG_NORELOAD_BIT = 7;
    localparam int CTRL_HALT_BIT    = 2;
    localparam int CTRL_DIR_BIT     = 4;
    localparam int CTRL_PRE_LSB     = 5;
    localparam int EVC_KIND_LSB     = 12;
    localparam logic [1:0] KIND_MATCH_ONLY = 2'd1;

    localparam logic [3:0] PAGE_CORE   = 4'h0;
    localparam logic [3:0] PAGE_MATCH  = 4'h1;
    localparam logic [3:0] PAGE_RELOAD = 4'h2;
    localparam logic [3:0] PAGE_EVENT  = 4'h3;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CFG, SEL_CTRL, SEL_LIMIT,
        SEL_MATCH, SEL_RELOAD, SEL_SMASK, SEL_EVCTL
    } reg_sel_e;

endpackage

// File: rtl/mtim_presc.sv
module mtim_presc #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] preset,
    output logic             tick
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q >= preset);
        div_d = div_q;
        if (run) div_d = tick ? '0 : div_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/mtim_evt_bank.sv
module mtim_evt_bank
    import mtim_pkg::*;
#(
    parameter int N_EV  = 16,
    parameter int CNT_W = 32,
    parameter int IDX_W = 4
) (
    input  logic                       tick,
    input  logic [CNT_W-1:0]           count,
    input  logic [N_EV-1:0][CNT_W-1:0] match,
    input  logic [N_EV-1:0][IDX_W-1:0] sel,
    input  logic [N_EV-1:0][1:0]       kind,
    input  logic [N_EV-1:0]            state_ok,
    output logic [N_EV-1:0]            fired
);
    for (genvar e = 0; e < N_EV; e++) begin : g_ev
        always_comb begin
            fired[e] = tick && state_ok[e] && (kind[e] == KIND_MATCH_ONLY)
                       && (match[sel[e]] == count);
        end
    end
endmodule

// File: rtl/match_event_timer.sv
module match_event_timer
    import mtim_pkg::*;
#(
    parameter int N_EV   = 16,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_EV-1:0]   evt_fired
);
    localparam int IDX_W = $clog2(N_EV);

    typedef struct packed {
        logic                       unify;
        logic                       noreload;
        logic                       halt;
        logic                       dir;
        logic [PRE_W-1:0]           pre;
        logic [N_EV-1:0]            limit;
        logic [CNT_W-1:0]           cnt;
        logic [N_EV-1:0][CNT_W-1:0] match;
        logic [N_EV-1:0][CNT_W-1:0] reload;
        logic [N_EV-1:0][DATA_W-1:0] smask;
        logic [N_EV-1:0][IDX_W-1:0] sel;
        logic [N_EV-1:0][1:0]       kind;
    } state_t;

    state_t st_d, st_q;
    logic   tick, wrap;
    logic [N_EV-1:0] state_ok;
    reg_sel_e   rsel;
    logic [IDX_W-1:0] ridx;

    mtim_presc #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(!st_q.halt), .preset(st_q.pre), .tick(tick)
    );

    always_comb begin
        for (int e = 0; e < N_EV; e++) state_ok[e] = st_q.smask[e][0];
    end

    mtim_evt_bank #(.N_EV(N_EV), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bank (
        .tick(tick), .count(st_q.cnt), .match(st_q.match), .sel(st_q.sel),
        .kind(st_q.kind), .state_ok(state_ok), .fired(evt_fired)
    );

    // address decode
    always_comb begin
        logic [7:0] off;
        off  = bus_addr[7:0];
        rsel = SEL_NONE;
        ridx = '0;
        if (off[1:0] == 2'b00) begin
            case (bus_addr[11:8])
                PAGE_CORE: begin
                    if (off == 8'h00) rsel = SEL_CFG;
                    else if (off == 8'h04) rsel = SEL_CTRL;
                    else if (off == 8'h08) rsel = SEL_LIMIT;
                end
                PAGE_MATCH: if ((off >> (2 + IDX_W)) == 8'd0) begin
                    rsel = SEL_MATCH;
                    ridx = off[2 +: IDX_W];
                end
                PAGE_RELOAD: if ((off >> (2 + IDX_W)) == 8'd0) begin
                    rsel = SEL_RELOAD;
                    ridx = off[2 +: IDX_W];
                end
                PAGE_EVENT: if ((off >> (3 + IDX_W)) == 8'd0) begin
                    rsel = off[2] ? SEL_EVCTL : SEL_SMASK;
                    ridx = off[3 +: IDX_W];
                end
                default: rsel = SEL_NONE;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        wrap = |(evt_fired & st_q.limit);
        if (tick) st_d.cnt = wrap ? '0 : st_q.cnt + CNT_W'(1);
        if (wrap && !st_q.noreload) st_d.match = st_q.reload;
        if (bus_we) begin
            case (rsel)
                SEL_CFG: begin
                    st_d.unify    = bus_wdata[CFG_UNIFY_BIT];
                    st_d.noreload = bus_wdata[CFG_NORELOAD_BIT];
                end
                SEL_CTRL: begin
                    st_d.halt = bus_wdata[CTRL_HALT_BIT];
                    st_d.dir  = bus_wdata[CTRL_DIR_BIT];
                    st_d.pre  = bus_wdata[CTRL_PRE_LSB +: PRE_W];
                end
                SEL_LIMIT:  st_d.limit        = bus_wdata[N_EV-1:0];
                SEL_MATCH:  st_d.match[ridx]  = bus_wdata[CNT_W-1:0];
                SEL_RELOAD: st_d.reload[ridx] = bus_wdata[CNT_W-1:0];
                SEL_SMASK:  st_d.smask[ridx]  = bus_wdata;
                SEL_EVCTL: begin
                    st_d.sel[ridx]  = bus_wdata[IDX_W-1:0];
                    st_d.kind[ridx] = bus_wdata[EVC_KIND_LSB +: 2];
                end
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (rsel)
            SEL_CFG: begin
                bus_rdata[CFG_UNIFY_BIT]    = st_q.unify;
                bus_rdata[CFG_NORELOAD_BIT] = st_q.noreload;
            end
            SEL_CTRL: begin
                bus_rdata[CTRL_HALT_BIT]          = st_q.halt;
                bus_rdata[CTRL_DIR_BIT]           = st_q.dir;
                bus_rdata[CTRL_PRE_LSB +: PRE_W]  = st_q.pre;
            end
            SEL_LIMIT:  bus_rdata[N_EV-1:0]  = st_q.limit;
            SEL_MATCH:  bus_rdata[CNT_W-1:0] = st_q.match[ridx];
            SEL_RELOAD: bus_rdata[CNT_W-1:0] = st_q.reload[ridx];
            SEL_SMASK:  bus_rdata            = st_q.smask[ridx];
            SEL_EVCTL: begin
                bus_rdata[IDX_W-1:0]         = st_q.sel[ridx];
                bus_rdata[EVC_KIND_LSB +: 2] = st_q.kind[ridx];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mtim_checker.sv
module mtim_checker #(
    parameter int N_EV  = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             noreload,
    input logic             tick,
    input logic [N_EV-1:0]  limit,
    input logic [N_EV-1:0]  evt_fired,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] match0,
    input logic [CNT_W-1:0] reload0,
    input logic             bus_we,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata
);
    logic wrap_c, wr_m0;
    assign wrap_c = |(evt_fired & limit);
    assign wr_m0  = bus_we && (bus_addr == 12'h100);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap_c) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_limit_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_c |=> (cnt == '0));

    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (evt_fired == '0));

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(cnt));

    assert_reload_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_c && !noreload && !wr_m0) |=> (match0 == $past(reload0)));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m0 |=> (match0 == $past(bus_wdata[CNT_W-1:0])));
endmodule

bind match_event_timer mtim_checker #(.N_EV(N_EV), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .halt(st_q.halt), .noreload(st_q.noreload),
    .tick(tick), .limit(st_q.limit), .evt_fired(evt_fired), .cnt(st_q.cnt),
    .match0(st_q.match[0]), .reload0(st_q.reload[0]),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sim_match_event_timer.sv
module sim_match_event_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_fired;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    match_event_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_fired(evt_fired)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; lands on the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // falling edges until event 0 is seen
    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!evt_fired[0] && g < 2000);
    endtask

    task automatic t_reset_r1();
        logic [31:0] v;
        rd(12'h004, v); check("R1 ctrl", v, 32'h4);
        rd(12'h000, v); check("R1 cfg", v, 32'h0);
        rd(12'h008, v); check("R1 limit", v, 32'h0);
        rd(12'h114, v); check("R1 match5", v, 32'h0);
        rd(12'h31c, v); check("R1 evctl3", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R1 quiet", {16'h0, evt_fired}, 32'h0);
        end
    endtask

    task automatic t_setup_r2();
        logic [31:0] v;
        wr(12'h100, 32'd4);            // match0
        wr(12'h200, 32'd4);            // reload0
        wr(12'h104, 32'd2);            // match1
        wr(12'h300, 32'hffff_ffff);    // smask0
        wr(12'h304, 32'h0000_1000);    // ev0: slot 0, match only
        wr(12'h308, 32'h0);            // smask1 = 0
        wr(12'h30c, 32'h0000_1001);    // ev1: slot 1, but masked out
        wr(12'h310, 32'hffff_ffff);    // smask2
        wr(12'h314, 32'h0000_1000);    // ev2: slot 0
        wr(12'h318, 32'hffff_ffff);    // smask3
        wr(12'h31c, 32'h0000_0001);    // ev3: slot 1, kind 0
        wr(12'h008, 32'h1);            // limit = ev0
        rd(12'h304, v); check("R2 evctl0", v, 32'h1000);
        rd(12'h100, v); check("R2 match0", v, 32'd4);
        rd(12'h008, v); check("R2 limit", v, 32'h1);
        wr(12'h000, 32'h81);
        rd(12'h000, v); check("R2 cfg rb", v, 32'h81);
        wr(12'h000, 32'h0);            // unified cleared, reload on
        wr(12'h004, 32'h1fe0 | 32'h10);
        rd(12'h004, v); check("R2 ctrl rb", v, 32'h1ff0);
        wr(12'h004, 32'h10);           // run, direction bit set (inert)
    endtask

    task automatic t_period_r3();
        int g;
        gap(g);
        gap(g); check("R2 R4 period with inert bits", g, 5);
        gap(g); check("R4 period", g, 5);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check("R3 shared slot", {31'h0, evt_fired[2]}, {31'h0, evt_fired[0]});
            check("R7 disabled events", {30'h0, evt_fired[3], evt_fired[1]}, 32'h0);
        end
    endtask

    task automatic t_presc_r6();
        int g;
        wr(12'h004, 32'd2 << 5);
        gap(g);
        gap(g); check("R6 prescale 2", g, 15);
        gap(g); check("R6 prescale 2 again", g, 15);
        @(negedge clk);
        wr(12'h004, 32'h0);
        gap(g);
        gap(g); check("R6 prescale 0", g, 5);
    endtask

    task automatic t_halt_r5();
        int g;
        int seen;
        gap(g);
        wr(12'h004, 32'h4);            // counter wraps to 0, then holds
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (evt_fired != 16'h0) seen++;
        end
        check("R5 halted quiet", seen, 0);
        wr(12'h004, 32'h0);
        gap(g); check("R5 resume from held 0", g + 1, 5);
    endtask

    task automatic t_reload_r8();
        int g;
        gap(g);
        @(negedge clk);
        wr(12'h200, 32'd7);
        gap(g);                         // this wrap loads 7
        gap(g); check("R8 reload at wrap", g, 8);
        @(negedge clk);
        wr(12'h000, 32'h80);
        wr(12'h200, 32'd2);
        gap(g);
        gap(g); check("R8 reload off", g, 8);
        gap(g); check("R8 reload off again", g, 8);
        @(negedge clk);
        wr(12'h000, 32'h0);
        gap(g);                         // loads 2
        gap(g); check("R8 reload back on", g, 3);
    endtask

    task automatic t_collide_r10();
        int g;
        @(negedge clk);
        wr(12'h200, 32'd6);
        gap(g);                         // loads 6
        gap(g); check("R8 reload 6", g, 7);
        wr(12'h100, 32'd3);             // lands on the wrap edge
        gap(g); check("R10 write beats reload", g + 1, 4);
        gap(g); check("R10 reload resumes", g, 7);
    endtask

    task automatic t_nolimit_r9();
        int g;
        int seen;
        gap(g);
        @(negedge clk);
        wr(12'h008, 32'h0);
        gap(g);
        check("R9 fires once", {31'h0, evt_fired[0]}, 32'h1);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (evt_fired[0]) seen++;
        end
        check("R9 no restart", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_setup_r2();
        t_period_r3();
        t_presc_r6();
        t_halt_r5();
        t_reload_r8();
        t_collide_r10();
        t_nolimit_r9();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule